// File: doc/BRIEF.md
# Parallel LCD Bus Master

This block is the host-side sequencer for an LCD controller that sits on an 8-bit parallel bus. The host places one access at a time on a request/done handshake: a read or write flag, the level for the register-select (RS) line and, for writes, a data byte. The block then plays out the bus cycle and pulses `done`. For reads, `rdata` returns the captured byte.

Two strobe styles can be chosen at run time. In the first style, separate active-low read and write strobes are used. In the second, an active-high enable is paired with a read/not-write level. Four programmable fields set the timing, all counted in clock periods:
- the address setup/hold count;
- the strobe-active width;
- the wait count;
- a selector for the length of the recovery gap after each access.

Optionally, the block follows each access with status reads. It repeats them until none of the masked status bits shows busy. The busy sense and the RS level used for these reads are both configurable.

The configuration arrives as plain input ports. The block samples it when a request is taken, so a host may reprogram freely while a transfer is still running.

Top module: `lcd_bus_master`

## Requirements
- R1: After reset and whenever idle, `ready` is high and the bus is quiet: `done`, `lcd_e` and `lcd_d_oe` are low, while `lcd_rd_n`, `lcd_wr_n` and `lcd_rw` are high. `rdata` resets to 0.
- R2: A request is taken only on a clock edge where `ready` and `req` are both high. A request raised while a transfer is running has no effect on that transfer's pins, duration or data.
- R3: Let S = `cfg_setup`+1. For S cycles before each strobe and S cycles after it, `lcd_rs` (and `lcd_rw` in enable mode) holds the access's level. The first strobe therefore starts in the (S+1)-th cycle after the accepting edge.
- R4: The strobe lasts W = `cfg_width`+1 cycles. With `cfg_mode6800`=0, exactly one of `lcd_rd_n`/`lcd_wr_n` goes low per access and `lcd_e` stays low. With `cfg_mode6800`=1, `lcd_e` goes high and both active-low strobes stay high.
- R5: In enable mode, `lcd_rw` is 1 for reads and 0 for writes across setup, strobe and hold. In strobe mode, `lcd_rw` stays 1.
- R6: After the hold, a recovery gap of R cycles follows. R = `cfg_wait`+1 when `cfg_recover_sel`=0, and R = W when it is 1. Between two strobes of one transfer the strobe is therefore off for exactly 2S+R cycles.
- R7: `done` is a single-cycle pulse. It rises (1+P)·(2S+W+R) cycles after the accepting edge, where P is the number of status reads. `ready` is high in the `done` cycle, so a request held high there is taken back-to-back.
- R8: For a write, `lcd_d_oe` is high for exactly the 2S+W cycles of the data access, and `lcd_d_out` equals the request's write byte throughout. `lcd_d_oe` never rises during a read or a status read.
- R9: For a read, `rdata` holds the `lcd_d_in` value present in the last strobe cycle of the data access. It is valid from the `done` cycle on.
- R10: With `cfg_busy_en`=1, a status read (RS = `cfg_busy_rs`) follows the data access. Status reads repeat until no bit selected by `cfg_busy_mask` is busy. A bit counts as busy when high if `cfg_busy_inv`=0, and when low if `cfg_busy_inv`=1. With `cfg_busy_en`=0, P=0. A zero mask gives P=1.
- R11: All `cfg_*` inputs are sampled at the accepting edge. Changes made during a transfer do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode6800 | input | 1 | 1: enable + R/W signalling, 0: separate RD/WR strobes |
| cfg_setup | input | SETUP_W | Address setup/hold count minus one |
| cfg_width | input | ACC_W | Strobe active width minus one |
| cfg_wait | input | WAIT_W | Wait count minus one |
| cfg_recover_sel | input | 1 | Recovery gap: 1 uses the strobe width, 0 uses the wait count |
| cfg_busy_en | input | 1 | Enable status polling after each access |
| cfg_busy_inv | input | 1 | 1: masked bits are busy when low |
| cfg_busy_rs | input | 1 | RS level during status reads |
| cfg_busy_mask | input | DATA_W | Status bits that are polled |
| req | input | 1 | Access request |
| req_read | input | 1 | 1 read, 0 write |
| req_rs | input | 1 | RS level for the data access |
| req_wdata | input | DATA_W | Write byte |
| ready | output | 1 | Idle, a request can be taken |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Captured read byte |
| lcd_rs | output | 1 | Register select |
| lcd_rd_n | output | 1 | Active-low read strobe |
| lcd_wr_n | output | 1 | Active-low write strobe |
| lcd_e | output | 1 | Active-high enable strobe |
| lcd_rw | output | 1 | Read/not-write level |
| lcd_d_out | output | DATA_W | Data bus output value |
| lcd_d_oe | output | 1 | Data bus output enable |
| lcd_d_in | input | DATA_W | Data bus input value |

## Verification
The `done` pulse of one transfer and the acceptance of the next request fall into the same clock cycle. The bench provokes this by raising the next request, with fresh configuration, in the very cycle it sees `done`, and then checks that the second transfer begins exactly S+1 cycles later with its own timing. A second overlap is the arrival of a request while a transfer is still running. The bench pulses a random request together with random configuration mid-transfer. It then judges that the running transfer keeps its strobe count, widths, gaps, data and duration.

// File: rtl/lcdm_pkg.sv
// Shared definitions for the parallel LCD bus master.
// Assumes nothing beyond IEEE 1800-2017 constant functions.
package lcdm_pkg;

    // Phase of the bus cycle currently being played out.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD,
        PH_RECOVER
    } lcdm_phase_e;

    // Largest of three widths, used to size the shared phase counter.
    function automatic int lcdm_max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/lcdm_cfg_latch.sv
// Configuration snapshot register.
// Captures the whole configuration vector on the accepting edge so that a
// transfer runs with the values present when it was taken. Resets to zero.
module lcdm_cfg_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Hold the configuration captured at the last accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end

endmodule

// File: rtl/lcdm_phase_ctr.sv
// Down counter that times every bus phase.
// Loading value v makes the current phase last v+1 cycles; zero flags the
// final cycle. Assumes load wins over counting.
module lcdm_phase_ctr #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);

    logic [CW-1:0] cnt;

    // Load a new phase length or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/lcdm_busy_eval.sv
// Status-byte busy evaluator.
// Reports busy when any masked bit sits at its busy level: high when inv is 0,
// low when inv is 1. Purely combinational.
module lcdm_busy_eval #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] status,
    input  logic [DW-1:0] mask,
    input  logic          inv,
    output logic          busy
);

    assign busy = |(mask & (status ^ {DW{inv}}));

endmodule

// File: rtl/lcd_bus_master.sv
// Parallel LCD bus master.
// Plays out one host access per request with programmable setup/hold, strobe
// width and recovery, in either separate-strobe or enable+R/W signalling, then
// optionally polls a status byte until no masked bit is busy. Configuration is
// sampled at acceptance; pins are decoded from registered state only.
module lcd_bus_master #(
    parameter int DATA_W  = 8,
    parameter int SETUP_W = 2,
    parameter int ACC_W   = 4,
    parameter int WAIT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_mode6800,
    input  logic [SETUP_W-1:0] cfg_setup,
    input  logic [ACC_W-1:0]  cfg_width,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic              cfg_recover_sel,
    input  logic              cfg_busy_en,
    input  logic              cfg_busy_inv,
    input  logic              cfg_busy_rs,
    input  logic [DATA_W-1:0] cfg_busy_mask,
    input  logic              req,
    input  logic              req_read,
    input  logic              req_rs,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              lcd_rs,
    output logic              lcd_rd_n,
    output logic              lcd_wr_n,
    output logic              lcd_e,
    output logic              lcd_rw,
    output logic [DATA_W-1:0] lcd_d_out,
    output logic              lcd_d_oe,
    input  logic [DATA_W-1:0] lcd_d_in
);
    import lcdm_pkg::*;

    localparam int CNT_W = lcdm_max3(SETUP_W, ACC_W, WAIT_W);
    localparam int CFG_W = DATA_W + SETUP_W + ACC_W + WAIT_W + 5;

    lcdm_phase_e       ph, ph_n;
    logic              accept, ld, zero, fin, go_poll, busy_now, busy_q;
    logic [CNT_W-1:0]  ld_val;
    logic              in_poll, cur_read, cur_rs;
    logic [DATA_W-1:0] cur_wdata, rdata_q;
    logic [CFG_W-1:0]  cfg_d, cfg_q;

    logic              l_mode, l_rsel, l_ben, l_binv, l_brs;
    logic [SETUP_W-1:0] l_setup;
    logic [ACC_W-1:0]  l_width;
    logic [WAIT_W-1:0] l_wait;
    logic [DATA_W-1:0] l_bmask;

    assign accept = (ph == PH_IDLE) && req;
    assign cfg_d  = {cfg_mode6800, cfg_setup, cfg_width, cfg_wait, cfg_recover_sel,
                     cfg_busy_en, cfg_busy_inv, cfg_busy_rs, cfg_busy_mask};
    assign {l_mode, l_setup, l_width, l_wait, l_rsel,
            l_ben, l_binv, l_brs, l_bmask} = cfg_q;

    lcdm_cfg_latch #(.W(CFG_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .load(accept), .d(cfg_d), .q(cfg_q)
    );

    lcdm_phase_ctr #(.CW(CNT_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val), .zero(zero)
    );

    lcdm_busy_eval #(.DW(DATA_W)) u_busy (
        .status(lcd_d_in), .mask(l_bmask), .inv(l_binv), .busy(busy_now)
    );

    // Phase sequencing: choose the next phase and the length to load.
    always_comb begin
        ph_n    = ph;
        ld      = 1'b0;
        ld_val  = '0;
        fin     = 1'b0;
        go_poll = 1'b0;
        case (ph)
            PH_IDLE: if (req) begin
                ph_n = PH_SETUP; ld = 1'b1; ld_val = CNT_W'(cfg_setup);
            end
            PH_SETUP: if (zero) begin
                ph_n = PH_STROBE; ld = 1'b1; ld_val = CNT_W'(l_width);
            end
            PH_STROBE: if (zero) begin
                ph_n = PH_HOLD; ld = 1'b1; ld_val = CNT_W'(l_setup);
            end
            PH_HOLD: if (zero) begin
                ph_n = PH_RECOVER; ld = 1'b1;
                ld_val = l_rsel ? CNT_W'(l_width) : CNT_W'(l_wait);
            end
            PH_RECOVER: if (zero) begin
                if (in_poll ? busy_q : l_ben) begin
                    ph_n = PH_SETUP; ld = 1'b1; ld_val = CNT_W'(l_setup);
                    go_poll = 1'b1;
                end else begin
                    ph_n = PH_IDLE; fin = 1'b1;
                end
            end
            default: ph_n = PH_IDLE;
        endcase
    end

    // State, request capture, read capture and busy sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph        <= PH_IDLE;
            done      <= 1'b0;
            in_poll   <= 1'b0;
            cur_read  <= 1'b0;
            cur_rs    <= 1'b0;
            cur_wdata <= '0;
            rdata_q   <= '0;
            busy_q    <= 1'b0;
        end else begin
            ph   <= ph_n;
            done <= fin;
            if (accept) begin
                cur_read  <= req_read;
                cur_rs    <= req_rs;
                cur_wdata <= req_wdata;
                in_poll   <= 1'b0;
            end
            if (ph == PH_RECOVER && zero) in_poll <= go_poll;
            if (ph == PH_STROBE && zero) begin
                if (in_poll)       busy_q  <= busy_now;
                else if (cur_read) rdata_q <= lcd_d_in;
            end
        end
    end

    logic acc_on, strb, acc_rd;
    assign acc_on = (ph == PH_SETUP) || (ph == PH_STROBE) || (ph == PH_HOLD);
    assign strb   = (ph == PH_STROBE);
    assign acc_rd = in_poll || cur_read;

    assign ready     = (ph == PH_IDLE);
    assign rdata     = rdata_q;
    assign lcd_rs    = acc_on && (in_poll ? l_brs : cur_rs);
    assign lcd_rw    = !(l_mode && acc_on && !acc_rd);
    assign lcd_e     = l_mode && strb;
    assign lcd_rd_n  = !(!l_mode && strb && acc_rd);
    assign lcd_wr_n  = !(!l_mode && strb && !acc_rd);
    assign lcd_d_oe  = acc_on && !acc_rd;
    assign lcd_d_out = lcd_d_oe ? cur_wdata : '0;

endmodule

// File: rtl/lcd_bus_master_chk.sv
// Property checker for the parallel LCD bus master, bound to the top module.
// Observes ports only; all properties are disabled while reset is asserted.
module lcd_bus_master_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ready,
    input logic              done,
    input logic              lcd_rs,
    input logic              lcd_rd_n,
    input logic              lcd_wr_n,
    input logic              lcd_e,
    input logic [DATA_W-1:0] lcd_d_out,
    input logic              lcd_d_oe
);

    logic strobe_on;
    assign strobe_on = !lcd_rd_n || !lcd_wr_n || lcd_e;

    a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!lcd_rd_n && !lcd_wr_n));

    a_r4_enable_excl: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_e |-> (lcd_rd_n && lcd_wr_n));

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (lcd_rd_n && lcd_wr_n && !lcd_e && !lcd_d_oe));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ready);

    a_r8_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_rd_n |-> !lcd_d_oe);

    a_r3_rs_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_on && $past(strobe_on)) |-> $stable(lcd_rs));

    a_r8_dout_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_d_oe && $past(lcd_d_oe)) |-> $stable(lcd_d_out));

endmodule

bind lcd_bus_master lcd_bus_master_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ready(ready), .done(done), .lcd_rs(lcd_rs),
    .lcd_rd_n(lcd_rd_n), .lcd_wr_n(lcd_wr_n), .lcd_e(lcd_e),
    .lcd_d_out(lcd_d_out), .lcd_d_oe(lcd_d_oe)
);

// File: tb/lcd_bus_master_bench.sv
// Self-checking bench: random transfers with directed corners, pin-level
// measurements per transfer compared against counts derived from the spec.
module lcd_bus_master_bench;

    localparam int NTXN = 300;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n;
    logic cfg_mode6800, cfg_recover_sel, cfg_busy_en, cfg_busy_inv, cfg_busy_rs;
    logic [1:0] cfg_setup, cfg_wait;
    logic [3:0] cfg_width;
    logic [7:0] cfg_busy_mask;
    logic req, req_read, req_rs;
    logic [7:0] req_wdata;
    logic ready, done, lcd_rs, lcd_rd_n, lcd_wr_n, lcd_e, lcd_rw, lcd_d_oe;
    logic [7:0] rdata, lcd_d_out, lcd_d_in;

    lcd_bus_master u_lcd_bus_master (
        .clk(clk), .rst_n(rst_n), .cfg_mode6800(cfg_mode6800), .cfg_setup(cfg_setup),
        .cfg_width(cfg_width), .cfg_wait(cfg_wait), .cfg_recover_sel(cfg_recover_sel),
        .cfg_busy_en(cfg_busy_en), .cfg_busy_inv(cfg_busy_inv), .cfg_busy_rs(cfg_busy_rs),
        .cfg_busy_mask(cfg_busy_mask), .req(req), .req_read(req_read), .req_rs(req_rs),
        .req_wdata(req_wdata), .ready(ready), .done(done), .rdata(rdata),
        .lcd_rs(lcd_rs), .lcd_rd_n(lcd_rd_n), .lcd_wr_n(lcd_wr_n), .lcd_e(lcd_e),
        .lcd_rw(lcd_rw), .lcd_d_out(lcd_d_out), .lcd_d_oe(lcd_d_oe), .lcd_d_in(lcd_d_in)
    );

    int checks = 0;
    int errors = 0;

    // Planned transfer
    logic t_mode, t_rsel, t_ben, t_binv, t_brs, t_read, t_rs;
    logic [1:0] t_setup, t_wait;
    logic [3:0] t_width;
    logic [7:0] t_mask, t_wdata, t_rdval;
    int t_nbusy;

    task automatic check_eq(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_polls(logic ben, logic [7:0] mask, int nbusy);
        if (!ben) return 0;
        if (mask == 8'h00) return 1;
        return nbusy + 1;
    endfunction

    function automatic logic [7:0] mk_busy(logic [7:0] mask, logic inv, logic [7:0] b);
        logic [7:0] r;
        logic found;
        r = b;
        found = 1'b0;
        for (int j = 0; j < 8; j++) begin
            if (mask[j] && !found) begin
                r[j] = !inv;
                found = 1'b1;
            end
        end
        return r;
    endfunction

    function automatic logic [7:0] mk_free(logic [7:0] mask, logic inv, logic [7:0] b);
        return inv ? (b | mask) : (b & ~mask);
    endfunction

    task automatic gen(int idx);
        t_mode  = 1'($urandom % 2);  t_setup = 2'($urandom % 4);
        t_width = 4'($urandom % 16); t_wait  = 2'($urandom % 4);
        t_rsel  = 1'($urandom % 2);  t_ben   = 1'($urandom % 2);
        t_binv  = 1'($urandom % 2);  t_brs   = 1'($urandom % 2);
        t_mask  = 8'($urandom % 256); t_read = 1'($urandom % 2);
        t_rs    = 1'($urandom % 2);  t_wdata = 8'($urandom % 256);
        t_rdval = 8'($urandom % 256); t_nbusy = int'($urandom % 4);
        case (idx)
            0: begin t_mode = 0; t_setup = 0; t_width = 0; t_wait = 0; t_rsel = 0;
                     t_ben = 0; t_read = 0; end
            1: begin t_mode = 0; t_setup = 3; t_width = 15; t_wait = 3; t_rsel = 1;
                     t_ben = 1; t_read = 1; t_mask = 8'h80; t_binv = 0; t_nbusy = 3; end
            2: begin t_mode = 1; t_ben = 1; t_mask = 8'h00; t_nbusy = 2; t_binv = 1; end
            3: begin t_mode = 1; t_read = 0; t_rsel = 0; t_wait = 3; t_ben = 1;
                     t_binv = 1; t_mask = 8'h81; t_nbusy = 1; end
            default: ;
        endcase
    endtask

    task automatic apply();
        cfg_mode6800 = t_mode; cfg_setup = t_setup; cfg_width = t_width;
        cfg_wait = t_wait; cfg_recover_sel = t_rsel; cfg_busy_en = t_ben;
        cfg_busy_inv = t_binv; cfg_busy_rs = t_brs; cfg_busy_mask = t_mask;
        req_read = t_read; req_rs = t_rs; req_wdata = t_wdata;
        req = 1'b1;
    endtask

    task automatic scramble();
        cfg_mode6800 = 1'($urandom % 2); cfg_setup = 2'($urandom % 4);
        cfg_width = 4'($urandom % 16); cfg_wait = 2'($urandom % 4);
        cfg_recover_sel = 1'($urandom % 2); cfg_busy_en = 1'($urandom % 2);
        cfg_busy_inv = 1'($urandom % 2); cfg_busy_rs = 1'($urandom % 2);
        cfg_busy_mask = 8'($urandom % 256); req_read = 1'($urandom % 2);
        req_rs = 1'($urandom % 2); req_wdata = 8'($urandom % 256);
    endtask

    // Runs one accepted transfer; called at the negedge where req is applied.
    task automatic run_txn(bit chain_next, int next_idx, bit poke);
        logic e_mode, e_read, e_rs, e_brs, e_binv;
        logic [7:0] e_mask, e_wdata, e_rdval;
        int s, w, r, p, a, tt, e_nbusy;
        int cyc, k, strb_cyc, strb_cnt, first_start, last_end, gap_bad;
        int rd_low, wr_low, e_hi, rw_low, oe_cyc, dout_bad, rs_bad, pin_bad;
        bit prev, strb, got_done, exp_rs;
        e_mode = t_mode; e_read = t_read; e_rs = t_rs; e_brs = t_brs; e_binv = t_binv;
        e_mask = t_mask; e_wdata = t_wdata; e_rdval = t_rdval; e_nbusy = t_nbusy;
        s = t_setup + 1; w = t_width + 1; r = t_rsel ? w : t_wait + 1;
        p = exp_polls(t_ben, t_mask, t_nbusy);
        a = 2 * s + w + r; tt = (1 + p) * a;
        cyc = 0; k = 0; strb_cyc = 0; strb_cnt = 0; first_start = 0; last_end = 0;
        gap_bad = 0; rd_low = 0; wr_low = 0; e_hi = 0; rw_low = 0; oe_cyc = 0;
        dout_bad = 0; rs_bad = 0; pin_bad = 0; prev = 0; got_done = 0;
        lcd_d_in = e_read ? e_rdval : 8'($urandom % 256);
        @(negedge clk);
        while (cyc <= 2000) begin
            cyc++;
            if (cyc == 1) req = 1'b0;
            if (poke && cyc == 2) begin scramble(); req = 1'b1; end   // R2 and R11 stimulus
            if (poke && cyc == 4) req = 1'b0;
            if (done) begin got_done = 1; break; end
            strb = e_mode ? lcd_e : (!lcd_rd_n || !lcd_wr_n);
            if (!lcd_rd_n) rd_low++;
            if (!lcd_wr_n) wr_low++;
            if (lcd_e) e_hi++;
            if (!lcd_rw) rw_low++;
            if (!lcd_rd_n && !lcd_wr_n) pin_bad++;
            if (lcd_d_oe) begin
                oe_cyc++;
                if (lcd_d_out != e_wdata) dout_bad++;
            end
            if (cyc <= 2 * s + w && lcd_rs != e_rs) rs_bad++;
            if (strb) begin
                strb_cyc++;
                if (!prev) begin
                    strb_cnt++;
                    if (strb_cnt == 1) first_start = cyc;
                    else if (cyc - last_end - 1 != 2 * s + r) gap_bad++;
                end
                exp_rs = (strb_cnt == 1) ? e_rs : e_brs;
                if (lcd_rs != exp_rs) rs_bad++;
            end else if (prev) begin
                last_end = cyc - 1;
                k++;
                lcd_d_in = (k <= e_nbusy) ? mk_busy(e_mask, e_binv, 8'($urandom % 256))
                                          : mk_free(e_mask, e_binv, 8'($urandom % 256));
            end
            prev = strb;
            @(negedge clk);
        end
        check_eq("R7 done seen (watchdog)", int'(got_done), 1);
        check_eq("R7 latency to done", cyc, tt + 1);
        check_eq("R7 ready in done cycle", int'(ready), 1);
        check_eq("R3 first strobe start", first_start, s + 1);
        check_eq("R6 strobe-off gap", gap_bad, 0);
        check_eq("R10 strobe count", strb_cnt, 1 + p);
        check_eq("R4 rd_n low cycles", rd_low, e_mode ? 0 : (e_read ? 1 + p : p) * w);
        check_eq("R4 wr_n low cycles", wr_low, (!e_mode && !e_read) ? w : 0);
        check_eq("R4 e high cycles", e_hi, e_mode ? (1 + p) * w : 0);
        check_eq("R4 both strobes low", pin_bad, 0);
        check_eq("R5 rw low cycles", rw_low, (e_mode && !e_read) ? 2 * s + w : 0);
        check_eq("R8 oe cycles", oe_cyc, e_read ? 0 : 2 * s + w);
        check_eq("R8 data mismatch", dout_bad, 0);
        check_eq("R10 rs level mismatch", rs_bad, 0);
        if (e_read) check_eq("R9 read data", int'(rdata), int'(e_rdval));
        if (poke) begin
            check_eq("R11 strobe cycles with mid-run cfg change", strb_cyc, (1 + p) * w);
            check_eq("R2 request during transfer ignored", cyc, tt + 1);
        end
        if (chain_next) begin
            gen(next_idx);
            apply();
        end
    endtask

    // Watchdog: an overrun counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit chain;
        void'($urandom(32'd1234));
        rst_n = 1'b0; req = 1'b0; lcd_d_in = '0;
        gen(0); apply(); req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset and idle state
        check_eq("R1 ready", int'(ready), 1);
        check_eq("R1 done", int'(done), 0);
        check_eq("R1 rd_n", int'(lcd_rd_n), 1);
        check_eq("R1 wr_n", int'(lcd_wr_n), 1);
        check_eq("R1 e", int'(lcd_e), 0);
        check_eq("R1 rw", int'(lcd_rw), 1);
        check_eq("R1 oe", int'(lcd_d_oe), 0);
        check_eq("R1 rdata", int'(rdata), 0);
        gen(0);
        apply();
        for (int i = 0; i < NTXN; i++) begin
            chain = (i < NTXN - 1) && ($urandom % 4 == 0);
            run_txn(chain, i + 1, (i > 3) && ($urandom % 2 == 0));
            if (!chain && i < NTXN - 1) begin
                gen(i + 1);
                repeat (1 + $urandom % 3) @(negedge clk);
                check_eq("R1 idle pins between transfers",
                         int'(ready && lcd_rd_n && lcd_wr_n && !lcd_e && !lcd_d_oe), 1);
                apply();
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule